// File: doc/BRIEF.md
# Clock Ratio Divider with Mode Decode

This block takes one fast source clock and divides it into a CPU-rate clock, a PCI-rate clock and an APIC-rate clock. Which ratios it uses, and whether it runs at all, comes from a three-bit frequency-select code. The source is either a synthesizer output or an external test clock. The CPU clock is always the source divided by 2. The PCI clock is the CPU clock divided by 2 or by 3, chosen by the most significant select bit, so the PCI rate stays the same in both speed grades. The APIC clock is the PCI clock divided by 2.

Every divider counts on source-clock edges and has an even total period, so each output has an exact 50% duty cycle. The select code passes through a synchronizer first. Any change in the decoded mode restarts all dividers together. One source cycle with all clocks low comes first, then all clocks rise at once, so no shortened first pulse can appear. The block also drives per-output enables for the tri-state pads, and a flag that marks unsupported codes.

Top module: `clk_ratio_div`

## Requirements
- R1: While rst_n is low, all three clock outputs are low, oe_o is 000 and rsv_o is 0.
- R2: Select code 000 gives oe_o = 000 (all pads high impedance) and rsv_o = 0, and holds all three clock outputs low.
- R3: Select code 011 gives oe_o = 111, rsv_o = 0, a CPU clock of period 2 source cycles (1 high, 1 low), a PCI clock of period 4 (2 high, 2 low) and an APIC clock of period 8 (4 high, 4 low).
- R4: Select code 111 gives oe_o = 111, rsv_o = 0, a CPU clock of period 2 (1/1), a PCI clock of period 6 (3/3) and an APIC clock of period 12 (6/6).
- R5: Select code 100 (test bypass) gives oe_o = 111, rsv_o = 0 and the same ratios as R4: source/2, source/6 and source/12.
- R6: Select codes 001, 010, 101 and 110 are reserved. They give rsv_o = 1 and oe_o = 111, and hold all three clocks low.
- R7: A new select value reaches oe_o and rsv_o on the third rising source edge after it is applied. The first two edges still show the previous mode.
- R8: On that third edge, all three clocks are low. On the fourth edge, a running mode raises all three clocks together, and each first pulse has full width.
- R9: Every PCI rising edge falls on a CPU rising edge, and every APIC rising edge falls on a PCI rising edge.
- sel bit order: sel[2] is the speed-grade bit, sel[1] and sel[0] follow; oe_o bit 0 is CPU, bit 1 PCI, bit 2 APIC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock (synthesizer output or test clock) |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 3 | Frequency-select code, asynchronous to clk |
| cpu_clk_o | output | 1 | CPU-rate clock |
| pci_clk_o | output | 1 | PCI-rate clock |
| apic_clk_o | output | 1 | APIC-rate clock |
| oe_o | output | 3 | Pad output enables: bit 0 CPU, bit 1 PCI, bit 2 APIC |
| rsv_o | output | 1 | High while a reserved code is selected |

## Verification
A divider counter that is off by one shows up at the ports within one PCI period. A counter that wraps at the wrong terminal count stretches or shrinks a high or low phase within one APIC period (at most 12 source cycles). A mode register that misses a change shows up on the third edge after the select moves, as a wrong enable or flag, or as a clock that fails to go quiet. A restart that does not clear the phase state gives a misaligned or truncated first pulse on the fourth edge. The bench therefore walks every ordered pair of distinct codes. For each pair it compares the output waveform cycle by cycle against periods computed from the code.

// File: rtl/clk_ratio_div_pkg.sv
package clk_ratio_div_pkg;
    localparam int SEL_W = 3;
    localparam int OE_W  = 3;

    typedef enum logic [2:0] {
        MD_OFF = 3'd0,
        MD_RSV = 3'd1,
        MD_LO  = 3'd2,
        MD_HI  = 3'd3,
        MD_TST = 3'd4
    } mode_e;
endpackage

// File: rtl/clk_ratio_div_sync.sv
module clk_ratio_div_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        for (int i = 0; i < STAGES; i++) begin
            st_d[i] = (i == 0) ? din : st_q[(i == 0) ? 0 : i - 1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= st_d[i];
        end
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/clk_ratio_div_dec.sv
module clk_ratio_div_dec
    import clk_ratio_div_pkg::*;
(
    input  logic [SEL_W-1:0] code,
    output mode_e            mode
);
    always_comb begin
        unique case (code)
            3'b000:  mode = MD_OFF;
            3'b011:  mode = MD_LO;
            3'b111:  mode = MD_HI;
            3'b100:  mode = MD_TST;
            default: mode = MD_RSV;
        endcase
    end
endmodule

// File: rtl/clk_ratio_div_core.sv
module clk_ratio_div_core
    import clk_ratio_div_pkg::*;
#(
    parameter int DIV_LO = 2,
    parameter int DIV_HI = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  mode_e           mode_in,
    output logic            cpu_clk,
    output logic            pci_clk,
    output logic            apic_clk,
    output logic [OE_W-1:0] oe,
    output logic            rsv
);
    localparam int PER_LO = 2 * DIV_LO;
    localparam int PER_HI = 2 * DIV_HI;
    localparam int PER_MX = (PER_HI > PER_LO) ? PER_HI : PER_LO;
    localparam int PW     = $clog2(PER_MX);
    localparam logic [PW-1:0] LAST_LO = PW'(PER_LO - 1);
    localparam logic [PW-1:0] LAST_HI = PW'(PER_HI - 1);
    localparam logic [PW-1:0] HALF_LO = PW'(DIV_LO);
    localparam logic [PW-1:0] HALF_HI = PW'(DIV_HI);

    typedef struct packed {
        mode_e           mode;
        logic [PW-1:0]   pc;
        logic            aph;
        logic            cpu;
        logic            pci;
        logic            apic;
        logic [OE_W-1:0] oe;
        logic            rsv;
    } state_t;

    state_t s_d, s_q;
    logic          run_d;
    logic          restart;
    logic [PW-1:0] last_d;
    logic [PW-1:0] half_d;

    always_comb begin
        s_d      = s_q;
        s_d.mode = mode_in;
        restart  = (mode_in != s_q.mode);
        run_d    = (mode_in == MD_LO) || (mode_in == MD_HI) || (mode_in == MD_TST);
        last_d   = (mode_in == MD_LO) ? LAST_LO : LAST_HI;
        half_d   = (mode_in == MD_LO) ? HALF_LO : HALF_HI;

        if (!run_d) begin
            s_d.pc  = '0;
            s_d.aph = 1'b1;
        end else if (restart) begin
            s_d.pc  = last_d;
            s_d.aph = 1'b1;
        end else if (s_q.pc >= last_d) begin
            s_d.pc  = '0;
            s_d.aph = ~s_q.aph;
        end else begin
            s_d.pc  = s_q.pc + 1'b1;
        end

        s_d.cpu  = run_d && !s_d.pc[0];
        s_d.pci  = run_d && (s_d.pc < half_d);
        s_d.apic = run_d && !s_d.aph;
        s_d.oe   = (mode_in == MD_OFF) ? '0 : '1;
        s_d.rsv  = (mode_in == MD_RSV);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mode <= MD_OFF;
            s_q.aph  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cpu_clk  = s_q.cpu;
    assign pci_clk  = s_q.pci;
    assign apic_clk = s_q.apic;
    assign oe       = s_q.oe;
    assign rsv      = s_q.rsv;
endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div
    import clk_ratio_div_pkg::*;
#(
    parameter int DIV_LO      = 2,
    parameter int DIV_HI      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             cpu_clk_o,
    output logic             pci_clk_o,
    output logic             apic_clk_o,
    output logic [OE_W-1:0]  oe_o,
    output logic             rsv_o
);
    logic [SEL_W-1:0] sel_s;
    mode_e            mode;

    clk_ratio_div_sync #(.W(SEL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sel),
        .dout  (sel_s)
    );

    clk_ratio_div_dec u_dec (
        .code (sel_s),
        .mode (mode)
    );

    clk_ratio_div_core #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_in  (mode),
        .cpu_clk  (cpu_clk_o),
        .pci_clk  (pci_clk_o),
        .apic_clk (apic_clk_o),
        .oe       (oe_o),
        .rsv      (rsv_o)
    );
endmodule

// File: rtl/clk_ratio_div_chk.sv
module clk_ratio_div_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_clk_o,
    input logic       pci_clk_o,
    input logic       apic_clk_o,
    input logic [2:0] oe_o,
    input logic       rsv_o
);
    // R2
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o == 3'b000) |-> (!cpu_clk_o && !pci_clk_o && !apic_clk_o && !rsv_o));

    // R6
    rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_o |-> (!cpu_clk_o && !pci_clk_o && !apic_clk_o && oe_o == 3'b111));

    // R3
    cpu_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_o |=> !cpu_clk_o);

    // R9
    pci_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pci_clk_o) |-> cpu_clk_o);

    // R9
    apic_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(apic_clk_o) |-> $rose(pci_clk_o));

    // R5
    oe_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o == 3'b000) || (oe_o == 3'b111));
endmodule

bind clk_ratio_div clk_ratio_div_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_clk_o  (cpu_clk_o),
    .pci_clk_o  (pci_clk_o),
    .apic_clk_o (apic_clk_o),
    .oe_o       (oe_o),
    .rsv_o      (rsv_o)
);

// File: tb/clk_ratio_div_test.sv
module clk_ratio_div_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = 3'b000;
    logic       cpu_clk_o, pci_clk_o, apic_clk_o, rsv_o;
    logic [2:0] oe_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    clk_ratio_div uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .cpu_clk_o  (cpu_clk_o),
        .pci_clk_o  (pci_clk_o),
        .apic_clk_o (apic_clk_o),
        .oe_o       (oe_o),
        .rsv_o      (rsv_o)
    );

    function automatic int half_of(int code);
        if (code == 3) return 2;
        if (code == 7 || code == 4) return 3;
        return 0;
    endfunction

    function automatic logic [3:0] flags_of(int code);
        if (code == 0) return 4'b0000;
        if (code == 3 || code == 7 || code == 4) return 4'b1110;
        return 4'b1111;
    endfunction

    // {cpu, pci, apic, oe[2:0], rsv} n cycles after the all-low restart cycle
    function automatic logic [6:0] exp_run(int code, int n);
        int h = half_of(code);
        logic c, p, a;
        if (h == 0 || n < 0) begin
            c = 0; p = 0; a = 0;
        end else begin
            c = (n % 2) == 0;
            p = (n % (2 * h)) < h;
            a = (n % (4 * h)) < 2 * h;
        end
        return {c, p, a, flags_of(code)};
    endfunction

    function automatic string tag_of(int code);
        case (code)
            0: return "R2";
            3: return "R3";
            7: return "R4";
            4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string req, logic [6:0] got, logic [6:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (t=%0t sel=%b)", req, got, exp, $time, sel);
        end
    endtask

    function automatic logic [6:0] outs();
        return {cpu_clk_o, pci_clk_o, apic_clk_o, oe_o, rsv_o};
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", outs(), 7'b0);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                if (a == b) continue;
                @(negedge clk);
                sel = a[2:0];
                repeat (6) @(negedge clk);
                sel = b[2:0];
                // R7: two edges still carry the previous mode's enables and flag
                for (int e = 0; e < 2; e++) begin
                    @(negedge clk);
                    n_chk++;
                    if ({oe_o, rsv_o} !== flags_of(a)) begin
                        n_bad++;
                        $display("FAIL R7: got %b expected %b", {oe_o, rsv_o}, flags_of(a));
                    end
                end
                // R7 R8: third edge applies the new mode with all clocks low
                @(negedge clk);
                check(b == 0 ? "R2" : "R7 R8", outs(), exp_run(b, -1));
                for (int n = 0; n < 24; n++) begin
                    @(negedge clk);
                    // R9 alignment is part of every running waveform compare
                    check(n == 0 ? "R8 R9" : tag_of(b), outs(), exp_run(b, n));
                end
            end
        end
        // R1: reset mid-run forces everything quiet
        sel = 3'b111;
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", outs(), 7'b0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            finish_run();
        end
    end
endmodule